// File: doc/BRIEF.md
# Indirect Serial Channel Register Access Unit

This unit is the host side of one asynchronous serial channel's register file. The host sees only a byte-wide control port. Almost every internal register is reached in two steps. When the pointer is at zero, a control write loads a register index into the pointer. The next accepted control access, either a read or a write, reaches the register that index names. After that access the pointer goes back to zero on its own. A control read made while the pointer is zero returns a status byte built from the channel's line inputs.

The unit keeps the character format: receiver and transmitter enables, character lengths, parity, stop-bit mode and x16 clocking. It also keeps the modem outputs and the break request, and presents all of these as decoded outputs for the shifting logic. A write to the reset register can clear this channel's format state. Control accesses that come too soon after an accepted one are dropped. This models the recovery time the channel needs between control accesses.

Top module: `ser_regif`

## Requirements
- R1: After reset the pointer is 0 and `ctl_rdata` is 0x00. Both enables, RTS, DTR, break and x16 are low. Parity and stop mode read 00, and both character lengths read 5.
- R2: An accepted control write while the pointer is 0 loads `ctl_wdata[3:0]` as the index. The next accepted control access, read or write, acts on that index. The pointer is then 0 again.
- R3: An accepted control read while the pointer is 0 puts the status byte on `ctl_rdata` after the clock edge. The bits are: bit 0 `rx_avail`, bit 2 `tx_empty`, bit 3 `dcd_in`, bit 5 `cts_in`, bit 7 `brk_det`. All other bits are 0.
- R4: Receive register (index 3): bit 0 drives `rx_en`. Bits 7:6 set `rx_bits` as 00=5, 01=7, 10=6, 11=8.
- R5: Transmit register (index 5): bits 6:5 set `tx_bits` with the same length encoding as R4. Bit 1 drives `rts_out`, bit 3 drives `tx_en`, bit 4 drives `brk_out` and bit 7 drives `dtr_out`.
- R6: Format register (index 4): bits 1:0 drive `par_mode` (00 none, 01 odd, 11 even). Bits 3:2 drive `stop_mode` (00 sync, 01 one, 10 one and a half, 11 two). Bit 6 drives `x16_clk`.
- R7: Reset register (index 9), bits 7:6: code 11 returns every format output to its R1 value. The code for this channel (10 when `CHAN_IS_B`=0, 01 when it is 1) does the same. The other channel's code and 00 change nothing.
- R8: After an accepted control access, every control access in the next `GAP_CYC` cycles (default 2) is dropped. A dropped access changes neither the pointer, the registers nor `ctl_rdata`.
- R9: If `ctl_wr` and `ctl_rd` are asserted in the same cycle, only the write is performed. `ctl_rdata` keeps its value.
- R10: A control read at a nonzero index returns 0x00. A write to an index other than 3, 4, 5 or 9 changes no output. In both cases the pointer returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_wr | input | 1 | Control port write strobe |
| ctl_rd | input | 1 | Control port read strobe |
| ctl_wdata | input | 8 | Control port write byte |
| ctl_rdata | output | 8 | Control port read byte, registered |
| rx_avail | input | 1 | Receive character available |
| tx_empty | input | 1 | Transmit buffer empty |
| dcd_in | input | 1 | Carrier detect line |
| cts_in | input | 1 | Clear-to-send line |
| brk_det | input | 1 | Break detected on receive line |
| rx_en | output | 1 | Receiver enable |
| rx_bits | output | 4 | Receive character length, 5 to 8 |
| tx_en | output | 1 | Transmitter enable |
| tx_bits | output | 4 | Transmit character length, 5 to 8 |
| rts_out | output | 1 | RTS modem output |
| dtr_out | output | 1 | DTR modem output |
| brk_out | output | 1 | Force break on transmit line |
| par_mode | output | 2 | Parity mode field |
| stop_mode | output | 2 | Stop-bit mode field |
| x16_clk | output | 1 | x16 clock mode select |

## Verification
Two pairs of functions can fall into the same cycle. The first pair is the write and read strobes, which the bench asserts together while the pointer is zero. That cycle must load the pointer and leave `ctl_rdata` unchanged, and a following data write proves the load took effect. The second pair is an accepted access and the recovery window. The bench issues a second strobe one cycle after an index load and then checks that a register the dropped access would have written keeps its value. It also checks that the pointer still selects that register.

// File: rtl/ser_regif_pkg.sv
package ser_regif_pkg;

  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_RXC = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FMT = 4'd4;
  localparam logic [IDX_W-1:0] IDX_TXC = 4'd5;
  localparam logic [IDX_W-1:0] IDX_RST = 4'd9;

  typedef enum logic [1:0] {
    RC_NONE = 2'b00,
    RC_CH_B = 2'b01,
    RC_CH_A = 2'b10,
    RC_BOTH = 2'b11
  } rst_code_e;

  // Nonmonotonic character length code to a bit count
  function automatic logic [3:0] len_decode(input logic [1:0] code);
    case (code)
      2'b00:   return 4'd5;
      2'b01:   return 4'd7;
      2'b10:   return 4'd6;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [7:0] status_pack(input logic rxa, input logic txe,
                                             input logic dcd, input logic cts,
                                             input logic brk);
    return {brk, 1'b0, cts, 1'b0, dcd, txe, 1'b0, rxa};
  endfunction

  function automatic logic reset_hits(input logic [1:0] code, input logic is_b);
    rst_code_e c;
    c = rst_code_e'(code);
    return (c == RC_BOTH) || (is_b ? (c == RC_CH_B) : (c == RC_CH_A));
  endfunction

endpackage

// File: rtl/ser_ptr_ctl.sv
module ser_ptr_ctl
  import ser_regif_pkg::*;
#(
  parameter int GAP_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic [IDX_W-1:0] wr_idx,
  output logic             acc_ok,
  output logic             idx_load,
  output logic             reg_wr,
  output logic             reg_rd,
  output logic [IDX_W-1:0] ptr_q
);

  logic gap_idle;
  logic ptr_zero;

  assign ptr_zero = (ptr_q == '0);
  assign acc_ok   = (ctl_wr || ctl_rd) && gap_idle;
  assign idx_load = acc_ok && ctl_wr && ptr_zero;
  assign reg_wr   = acc_ok && ctl_wr && !ptr_zero;
  assign reg_rd   = acc_ok && !ctl_wr && ctl_rd;

  always_ff @(posedge clk) begin
    if (!rst_n)              ptr_q <= '0;
    else if (idx_load)       ptr_q <= wr_idx;
    else if (reg_wr || reg_rd) ptr_q <= '0;
  end

  generate
    if (GAP_CYC > 0) begin : g_gap
      localparam int CW = $clog2(GAP_CYC + 1);
      localparam logic [CW-1:0] GAP_LD = CW'(GAP_CYC);
      logic [CW-1:0] gap_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n)              gap_cnt <= '0;
        else if (acc_ok)         gap_cnt <= GAP_LD;
        else if (gap_cnt != '0)  gap_cnt <= gap_cnt - 1'b1;
      end
      assign gap_idle = (gap_cnt == '0);
    end else begin : g_nogap
      assign gap_idle = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/ser_fmt_regs.sv
module ser_fmt_regs
  import ser_regif_pkg::*;
#(
  parameter bit CHAN_IS_B = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [IDX_W-1:0] ptr_q,
  input  logic [7:0]       wdata,
  output logic             fmt_clr,
  output logic             rx_en,
  output logic [3:0]       rx_bits,
  output logic             tx_en,
  output logic [3:0]       tx_bits,
  output logic             rts_out,
  output logic             dtr_out,
  output logic             brk_out,
  output logic [1:0]       par_mode,
  output logic [1:0]       stop_mode,
  output logic             x16_clk
);

  logic [1:0] rx_len_q, tx_len_q;
  logic       wr_rxc, wr_fmt, wr_txc;

  assign wr_rxc  = reg_wr && (ptr_q == IDX_RXC);
  assign wr_fmt  = reg_wr && (ptr_q == IDX_FMT);
  assign wr_txc  = reg_wr && (ptr_q == IDX_TXC);
  assign fmt_clr = reg_wr && (ptr_q == IDX_RST) && reset_hits(wdata[7:6], CHAN_IS_B);

  always_ff @(posedge clk) begin
    if (!rst_n || fmt_clr) begin
      rx_en    <= 1'b0;
      rx_len_q <= 2'b00;
    end else if (wr_rxc) begin
      rx_en    <= wdata[0];
      rx_len_q <= wdata[7:6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fmt_clr) begin
      par_mode  <= 2'b00;
      stop_mode <= 2'b00;
      x16_clk   <= 1'b0;
    end else if (wr_fmt) begin
      par_mode  <= wdata[1:0];
      stop_mode <= wdata[3:2];
      x16_clk   <= wdata[6];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || fmt_clr) begin
      rts_out  <= 1'b0;
      tx_en    <= 1'b0;
      brk_out  <= 1'b0;
      dtr_out  <= 1'b0;
      tx_len_q <= 2'b00;
    end else if (wr_txc) begin
      rts_out  <= wdata[1];
      tx_en    <= wdata[3];
      brk_out  <= wdata[4];
      dtr_out  <= wdata[7];
      tx_len_q <= wdata[6:5];
    end
  end

  assign rx_bits = len_decode(rx_len_q);
  assign tx_bits = len_decode(tx_len_q);

endmodule

// File: rtl/ser_status.sv
module ser_status
  import ser_regif_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_rd,
  input  logic [IDX_W-1:0] ptr_q,
  input  logic             rx_avail,
  input  logic             tx_empty,
  input  logic             dcd_in,
  input  logic             cts_in,
  input  logic             brk_det,
  output logic [7:0]       ctl_rdata
);

  logic [7:0] rd_sel;

  always_comb begin
    if (ptr_q == '0) rd_sel = status_pack(rx_avail, tx_empty, dcd_in, cts_in, brk_det);
    else             rd_sel = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_rdata <= 8'h00;
    else if (reg_rd) ctl_rdata <= rd_sel;
  end

endmodule

// File: rtl/ser_regif.sv
module ser_regif
  import ser_regif_pkg::*;
#(
  parameter int GAP_CYC   = 2,
  parameter bit CHAN_IS_B = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       ctl_rd,
  input  logic [7:0] ctl_wdata,
  output logic [7:0] ctl_rdata,
  input  logic       rx_avail,
  input  logic       tx_empty,
  input  logic       dcd_in,
  input  logic       cts_in,
  input  logic       brk_det,
  output logic       rx_en,
  output logic [3:0] rx_bits,
  output logic       tx_en,
  output logic [3:0] tx_bits,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       brk_out,
  output logic [1:0] par_mode,
  output logic [1:0] stop_mode,
  output logic       x16_clk
);

  logic             acc_ok;
  logic             idx_load;
  logic             reg_wr;
  logic             reg_rd;
  logic             fmt_clr;
  logic [IDX_W-1:0] ptr_q;

  ser_ptr_ctl #(.GAP_CYC(GAP_CYC)) u_ptr (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .wr_idx(ctl_wdata[IDX_W-1:0]), .acc_ok(acc_ok), .idx_load(idx_load),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .ptr_q(ptr_q)
  );

  ser_fmt_regs #(.CHAN_IS_B(CHAN_IS_B)) u_fmt (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .ptr_q(ptr_q),
    .wdata(ctl_wdata), .fmt_clr(fmt_clr), .rx_en(rx_en), .rx_bits(rx_bits),
    .tx_en(tx_en), .tx_bits(tx_bits), .rts_out(rts_out), .dtr_out(dtr_out),
    .brk_out(brk_out), .par_mode(par_mode), .stop_mode(stop_mode),
    .x16_clk(x16_clk)
  );

  ser_status u_stat (
    .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .ptr_q(ptr_q),
    .rx_avail(rx_avail), .tx_empty(tx_empty), .dcd_in(dcd_in),
    .cts_in(cts_in), .brk_det(brk_det), .ctl_rdata(ctl_rdata)
  );

endmodule

// File: rtl/ser_regif_chk.sv
module ser_regif_chk #(
  parameter int GAP_CYC = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       ctl_rd,
  input logic       acc_ok,
  input logic       fmt_clr,
  input logic [3:0] ptr_q,
  input logic [7:0] ctl_rdata,
  input logic       rx_en,
  input logic       tx_en,
  input logic       rts_out,
  input logic       dtr_out,
  input logic [3:0] rx_bits,
  input logic [3:0] tx_bits
);

  AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok && ptr_q != 4'd0) |=> (ptr_q == 4'd0)); // R2

  AST_GAP_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    ((GAP_CYC > 0) && acc_ok) |=> !acc_ok); // R8

  AST_CLR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_clr |=> (!rx_en && !tx_en && !rts_out && !dtr_out)); // R7

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_ok && ctl_rd && !ctl_wr) |=> $stable(ctl_rdata)); // R9

  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_bits >= 4'd5 && rx_bits <= 4'd8 && tx_bits >= 4'd5 && tx_bits <= 4'd8)); // R4

endmodule

bind ser_regif ser_regif_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
  .acc_ok(acc_ok), .fmt_clr(fmt_clr), .ptr_q(ptr_q), .ctl_rdata(ctl_rdata),
  .rx_en(rx_en), .tx_en(tx_en), .rts_out(rts_out), .dtr_out(dtr_out),
  .rx_bits(rx_bits), .tx_bits(tx_bits)
);

// File: tb/sim_ser_regif.sv
`timescale 1ns/1ps
module sim_ser_regif;

  localparam int GAP = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctl_wr = 1'b0, ctl_rd = 1'b0;
  logic [7:0] ctl_wdata = 8'h00;
  logic [7:0] ctl_rdata;
  logic       rx_avail = 1'b0, tx_empty = 1'b0, dcd_in = 1'b0, cts_in = 1'b0, brk_det = 1'b0;
  logic       rx_en, tx_en, rts_out, dtr_out, brk_out, x16_clk;
  logic [3:0] rx_bits, tx_bits;
  logic [1:0] par_mode, stop_mode;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  ser_regif #(.GAP_CYC(GAP), .CHAN_IS_B(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rd(ctl_rd),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .rx_avail(rx_avail),
    .tx_empty(tx_empty), .dcd_in(dcd_in), .cts_in(cts_in), .brk_det(brk_det),
    .rx_en(rx_en), .rx_bits(rx_bits), .tx_en(tx_en), .tx_bits(tx_bits),
    .rts_out(rts_out), .dtr_out(dtr_out), .brk_out(brk_out),
    .par_mode(par_mode), .stop_mode(stop_mode), .x16_clk(x16_clk)
  );

  // observation: {rx_en, rx_bits, tx_en, tx_bits, rts, dtr, brk, par, stop, x16}
  localparam logic [17:0] OBS_RST = {1'b0,4'd5,1'b0,4'd5,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0};
  localparam int NV = 9;
  // entry: {index, write byte, expected observation}
  localparam logic [29:0] VEC [NV] = '{
    {4'd3, 8'hC1, 1'b1,4'd8,1'b0,4'd5,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0},
    {4'd3, 8'h40, 1'b0,4'd7,1'b0,4'd5,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0},
    {4'd3, 8'h81, 1'b1,4'd6,1'b0,4'd5,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0},
    {4'd5, 8'hEA, 1'b1,4'd6,1'b1,4'd8,1'b1,1'b1,1'b0,2'b00,2'b00,1'b0},
    {4'd5, 8'h38, 1'b1,4'd6,1'b1,4'd7,1'b0,1'b0,1'b1,2'b00,2'b00,1'b0},
    {4'd5, 8'h40, 1'b1,4'd6,1'b0,4'd6,1'b0,1'b0,1'b0,2'b00,2'b00,1'b0},
    {4'd4, 8'h47, 1'b1,4'd6,1'b0,4'd6,1'b0,1'b0,1'b0,2'b11,2'b01,1'b1},
    {4'd4, 8'h09, 1'b1,4'd6,1'b0,4'd6,1'b0,1'b0,1'b0,2'b01,2'b10,1'b0},
    {4'd7, 8'hFF, 1'b1,4'd6,1'b0,4'd6,1'b0,1'b0,1'b0,2'b01,2'b10,1'b0}
  };

  function automatic logic [17:0] obs();
    return {rx_en, rx_bits, tx_en, tx_bits, rts_out, dtr_out, brk_out,
            par_mode, stop_mode, x16_clk};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic strobe(input logic wr, input logic rd, input logic [7:0] d, input int idle);
    @(negedge clk);
    ctl_wr = wr; ctl_rd = rd; ctl_wdata = d;
    @(negedge clk);
    ctl_wr = 1'b0; ctl_rd = 1'b0;
    repeat (idle) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
    strobe(1'b1, 1'b0, {4'h0, idx}, GAP);
    strobe(1'b1, 1'b0, d, GAP);
  endtask

  task automatic rd_status();
    strobe(1'b0, 1'b1, 8'h00, GAP);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs", 32'(obs()), 32'(OBS_RST));
    check("R1 rdata", 32'(ctl_rdata), 32'h00);

    // table walk: R4 R5 R6 R10 (index 7 has no effect)
    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][29:26], VEC[i][25:18]);
      check("R4/R5/R6/R10 table", 32'(obs()), 32'(VEC[i][17:0]));
    end

    // R3 status patterns
    rx_avail = 1; tx_empty = 0; dcd_in = 1; cts_in = 0; brk_det = 1;
    rd_status();
    check("R3 status a", 32'(ctl_rdata), 32'h89);
    rx_avail = 0; tx_empty = 1; dcd_in = 0; cts_in = 1; brk_det = 0;
    rd_status();
    check("R3 status b", 32'(ctl_rdata), 32'h24);

    // R10 read at nonzero index gives 0, R2 pointer then back at 0
    strobe(1'b1, 1'b0, 8'h05, GAP);
    rd_status();
    check("R10 read idx5", 32'(ctl_rdata), 32'h00);
    rd_status();
    check("R2 ptr back after read", 32'(ctl_rdata), 32'h24);

    // R2 pointer back after write: a write now loads the index, no register change
    wr_reg(4'd3, 8'hC1);
    strobe(1'b1, 1'b0, 8'h40, GAP);  // index 0 load, pointer stays 0
    rd_status();
    check("R2 ptr back after write", 32'(ctl_rdata), 32'h24);
    check("R2 rx kept", 32'({rx_en, rx_bits}), 32'({1'b1, 4'd8}));

    // R8 recovery gap: second strobe one cycle after index load is dropped
    strobe(1'b1, 1'b0, 8'h03, 0);
    strobe(1'b1, 1'b0, 8'h00, GAP);
    check("R8 dropped write", 32'({rx_en, rx_bits}), 32'({1'b1, 4'd8}));
    rd_status();                    // pointer still 3 -> reads 0x00
    check("R8 pointer kept", 32'(ctl_rdata), 32'h00);
    rd_status();
    check("R8 pointer returned", 32'(ctl_rdata), 32'h24);

    // R9 simultaneous read and write: write wins, rdata unchanged
    rx_avail = 1;
    strobe(1'b1, 1'b1, 8'h03, GAP);
    check("R9 rdata held", 32'(ctl_rdata), 32'h24);
    strobe(1'b1, 1'b0, 8'h40, GAP);
    check("R9 write took index", 32'({rx_en, rx_bits}), 32'({1'b0, 4'd7}));

    // R7 reset codes (channel A)
    wr_reg(4'd5, 8'hEA);
    wr_reg(4'd4, 8'h47);
    wr_reg(4'd9, 8'h40);            // channel B code: ignored
    check("R7 other channel", 32'({tx_en, dtr_out, rts_out, x16_clk}), 32'h0F);
    wr_reg(4'd9, 8'h00);
    check("R7 code none", 32'({tx_en, dtr_out, rts_out, x16_clk}), 32'h0F);
    wr_reg(4'd9, 8'h80);            // own channel
    check("R7 own channel", 32'(obs()), 32'(OBS_RST));
    wr_reg(4'd3, 8'hC1);
    wr_reg(4'd5, 8'hEA);
    wr_reg(4'd9, 8'hC0);            // both
    check("R7 hardware", 32'(obs()), 32'(OBS_RST));

    // R1 again after a mid-run reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rdata after reset", 32'(ctl_rdata), 32'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule